// File: doc/BRIEF.md
# Vectored Interrupt Message Controller

This block collects 64 interrupt inputs and turns each one that is pending, unmasked and enabled into a vector message on a valid/ready output. A message carries the source's own 8-bit vector byte and 8-bit route byte, both set by software. Each source can be set as edge or level triggered and as active-high or active-low. The inputs may be asynchronous: each one passes through a two-flop synchronizer before the polarity correction and the edge detection.

Software uses a 32-bit register port with byte enables. Every per-source control is a pair of words, with source n at bit n%32 of the word n/32, and the upper word 4 bytes above the lower one. Once a message for a source has been accepted, that source stays quiet until software writes a 1 to its bit in the clear register. That write is the end-of-interrupt. It also drops a latched edge.

Top module: `vecmsg_intc`

## Requirements
- R1: After reset every source is masked (mask words read 0xFFFFFFFF), and the enable, trigger-mode, polarity, vector, route and spare words all read 0. No message is valid.
- R2: Writes honour the byte enables, and reads return the stored value one cycle after the request. The words are: mask at 0x20/0x24, message enable at 0x40/0x44, trigger mode at 0x60/0x64, polarity at 0x3E0/0x3E4, spare storage at 0xC0 and 0xE0, the route byte of source n at 0x100+n and the vector byte of source n at 0x200+n.
- R3: A level source (trigger bit 0) is pending whenever its synchronized input is at the active level. With polarity bit 0 the active level is high; with polarity bit 1 it is low. Reads at 0x80/0x84 return the raw pending bits.
- R4: An edge source (trigger bit 1) latches pending on a rising edge when its polarity bit is 0, or on a falling edge when it is 1. The latch holds after the input returns, and the opposite edge does not set it.
- R5: A write to 0x80/0x84 clears the latched pending and the in-service state of every source whose bit is 1. Bits written as 0 have no effect.
- R6: A message is sent only for a source whose mask bit is 0 and whose enable bit is 1. It carries that source's vector byte and route byte.
- R7: When several sources are eligible, the lowest-numbered one is sent first.
- R8: While the message is valid and ready is low, valid, vector and route do not change.
- R9: Once a message is accepted, its source sends nothing more until it is cleared. A level source that is still active is sent again after the clear.
- R10: The two spare words have no effect on message generation.
- R11: If a clear and a new edge for the same source fall in the same cycle, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Raw interrupt inputs, may be asynchronous |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for writes |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Vector byte of the sent source |
| msg_route | output | 8 | Route byte of the sent source |

## Verification
Two events can land on the same source in the same clock edge: the end-of-interrupt clear and a newly detected edge. The bench times a rising input so that it reaches the edge detector on exactly the edge that samples a clear write. It then reads the pending bit and expects it to still be set. A second clear, one cycle later, must drop the bit. The bench also overlaps a handshake with the choice of the next source, and expects the lower-numbered source to go first and the other one to follow it.

// File: rtl/vecmsg_intc.sv
module vecmsg_intc #(
  parameter int NSRC = 64,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            bus_req,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  input  logic [3:0]      bus_be,
  output logic [31:0]     bus_rdata,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [7:0]      msg_vector,
  output logic [7:0]      msg_route
);
  localparam int NW = NSRC / 32;
  localparam int NB = NSRC / 4;
  localparam int SW = $clog2(NSRC);
  localparam int WI = AW - 2;
  localparam int OFF_MASK = 'h020;
  localparam int OFF_EN   = 'h040;
  localparam int OFF_MODE = 'h060;
  localparam int OFF_CLR  = 'h080;
  localparam int OFF_SPA  = 'h0C0;
  localparam int OFF_SPB  = 'h0E0;
  localparam int OFF_RTE  = 'h100;
  localparam int OFF_VEC  = 'h200;
  localparam int OFF_POL  = 'h3E0;

  logic [WI-1:0]   widx;
  logic            wr;
  logic [NSRC-1:0] mask_q, en_q, mode_q, pol_q;
  logic [31:0]     spa_q, spb_q;
  logic [7:0]      vec_q [NSRC];
  logic [7:0]      rte_q [NSRC];
  logic [NSRC-1:0] sync1_q, sync2_q, prev_q, latch_q, insvc_q;
  logic [NSRC-1:0] norm, rise, pend, elig, clr_w, acc_hot;
  logic [SW-1:0]   pick, src_q;
  logic [31:0]     rd_mux;

  assign widx = bus_addr[AW-1:2];
  assign wr   = bus_req & bus_we;

  function automatic logic at(input logic [WI-1:0] wi, input int off);
    return wi == WI'(off / 4);
  endfunction

  function automatic logic [31:0] bmerge(input logic [31:0] o, input logic [31:0] d,
                                         input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? d[8*i +: 8] : o[8*i +: 8];
    return r;
  endfunction

  always_comb begin
    clr_w = '0;
    for (int w = 0; w < NW; w++)
      if (wr && at(widx, OFF_CLR + 4*w))
        clr_w[w*32 +: 32] = bmerge(32'h0, bus_wdata, bus_be);
  end

  assign norm    = sync2_q ^ pol_q;
  assign rise    = norm & ~prev_q;
  assign pend    = (mode_q & latch_q) | (~mode_q & norm);
  assign elig    = pend & ~mask_q & en_q & ~insvc_q;
  assign acc_hot = (msg_valid && msg_ready) ? (NSRC'(1) << src_q) : '0;

  always_comb begin
    pick = '0;
    for (int s = NSRC - 1; s >= 0; s--)
      if (elig[s]) pick = SW'(s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      latch_q <= '0;
      insvc_q <= '0;
    end else begin
      sync1_q <= irq_in;
      sync2_q <= sync1_q;
      prev_q  <= norm;
      latch_q <= (latch_q & ~clr_w) | (rise & mode_q);
      insvc_q <= (insvc_q & ~clr_w) | acc_hot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      spa_q  <= '0;
      spb_q  <= '0;
      for (int s = 0; s < NSRC; s++) begin
        vec_q[s] <= '0;
        rte_q[s] <= '0;
      end
    end else if (wr) begin
      for (int w = 0; w < NW; w++) begin
        if (at(widx, OFF_MASK + 4*w)) mask_q[w*32 +: 32] <= bmerge(mask_q[w*32 +: 32], bus_wdata, bus_be);
        if (at(widx, OFF_EN   + 4*w)) en_q[w*32 +: 32]   <= bmerge(en_q[w*32 +: 32],   bus_wdata, bus_be);
        if (at(widx, OFF_MODE + 4*w)) mode_q[w*32 +: 32] <= bmerge(mode_q[w*32 +: 32], bus_wdata, bus_be);
        if (at(widx, OFF_POL  + 4*w)) pol_q[w*32 +: 32]  <= bmerge(pol_q[w*32 +: 32],  bus_wdata, bus_be);
      end
      if (at(widx, OFF_SPA)) spa_q <= bmerge(spa_q, bus_wdata, bus_be);
      if (at(widx, OFF_SPB)) spb_q <= bmerge(spb_q, bus_wdata, bus_be);
      for (int s = 0; s < NSRC; s++) begin
        if (at(widx, OFF_RTE + 4*(s/4)) && bus_be[s%4]) rte_q[s] <= bus_wdata[8*(s%4) +: 8];
        if (at(widx, OFF_VEC + 4*(s/4)) && bus_be[s%4]) vec_q[s] <= bus_wdata[8*(s%4) +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      src_q      <= '0;
      msg_vector <= '0;
      msg_route  <= '0;
    end else if (!msg_valid) begin
      if (|elig) begin
        msg_valid  <= 1'b1;
        src_q      <= pick;
        msg_vector <= vec_q[pick];
        msg_route  <= rte_q[pick];
      end
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NW; w++) begin
      if (at(widx, OFF_MASK + 4*w)) rd_mux = mask_q[w*32 +: 32];
      if (at(widx, OFF_EN   + 4*w)) rd_mux = en_q[w*32 +: 32];
      if (at(widx, OFF_MODE + 4*w)) rd_mux = mode_q[w*32 +: 32];
      if (at(widx, OFF_POL  + 4*w)) rd_mux = pol_q[w*32 +: 32];
      if (at(widx, OFF_CLR  + 4*w)) rd_mux = pend[w*32 +: 32];
    end
    if (at(widx, OFF_SPA)) rd_mux = spa_q;
    if (at(widx, OFF_SPB)) rd_mux = spb_q;
    for (int k = 0; k < NB; k++) begin
      if (at(widx, OFF_RTE + 4*k))
        for (int j = 0; j < 4; j++) rd_mux[8*j +: 8] = rte_q[4*k + j];
      if (at(widx, OFF_VEC + 4*k))
        for (int j = 0; j < 4; j++) rd_mux[8*j +: 8] = vec_q[4*k + j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_req && !bus_we) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/vecmsg_intc_chk.sv
module vecmsg_intc_chk #(
  parameter int NSRC = 64,
  parameter int SW   = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            msg_valid,
  input logic            msg_ready,
  input logic [7:0]      msg_vector,
  input logic [7:0]      msg_route,
  input logic [SW-1:0]   src_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] elig,
  input logic [NSRC-1:0] insvc_q
);
  logic [NSRC-1:0] gate_prev, elig_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_prev <= '0;
      elig_prev <= '0;
    end else begin
      gate_prev <= en_q & ~mask_q;
      elig_prev <= elig;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_route)); // R8
  AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid); // R9
  AST_ACCEPT_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> insvc_q[$past(src_q)]); // R9
  AST_GATED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> gate_prev[src_q]); // R6
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> elig_prev[src_q] && ((elig_prev & ((NSRC'(1) << src_q) - NSRC'(1))) == '0)); // R7
endmodule

bind vecmsg_intc vecmsg_intc_chk #(.NSRC(NSRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_route(msg_route), .src_q(src_q),
  .mask_q(mask_q), .en_q(en_q), .elig(elig), .insvc_q(insvc_q)
);

// File: tb/vecmsg_intc_tb_top.sv
module vecmsg_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_vector, msg_route;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk; // 20 ns period, 50 MHz

  vecmsg_intc dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_route(msg_route)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_req = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic take(input string req, input int s);
    chk({req, " valid"}, 32'(msg_valid), 32'd1);
    chk({req, " vector"}, 32'(msg_vector), 32'(8'h40 + s));
    chk({req, " route"}, 32'(msg_route), 32'(8'hC0 ^ s));
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h020, d); chk("R1 mask0", d, 32'hFFFFFFFF);
    rd(12'h024, d); chk("R1 mask1", d, 32'hFFFFFFFF);
    rd(12'h040, d); chk("R1 en0", d, 0);
    rd(12'h064, d); chk("R1 mode1", d, 0);
    rd(12'h3E0, d); chk("R1 pol0", d, 0);
    rd(12'h23C, d); chk("R1 vec", d, 0);
    rd(12'h0C0, d); chk("R1 spare", d, 0);
    chk("R1 no msg", 32'(msg_valid), 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(12'h020, 32'h12345678, 4'b0011);
    rd(12'h020, d); chk("R2 mask byte enables", d, 32'hFFFF5678);
    wr(12'h020, 32'hFFFFFFFF);
    wr(12'h104, 32'hA1B2C3D4);
    rd(12'h104, d); chk("R2 route word", d, 32'hA1B2C3D4);
    wr(12'h0E0, 32'h5A5A0F0F, 4'b1000);
    rd(12'h0E0, d); chk("R2 spare byte", d, 32'h5A000000);
    for (int k = 0; k < 16; k++) begin
      logic [31:0] v, r;
      for (int j = 0; j < 4; j++) begin
        v[8*j +: 8] = 8'h40 + 8'(4*k + j);
        r[8*j +: 8] = 8'hC0 ^ 8'(4*k + j);
      end
      wr(12'h200 + 12'(4*k), v);
      wr(12'h100 + 12'(4*k), r);
    end
    rd(12'h228, d); chk("R2 vector source 40", d, 32'h6B6A6968);
  endtask

  task automatic t_level;
    logic [31:0] d;
    irq_in[5] = 1; idle(4);
    rd(12'h080, d); chk("R3 level high pending", d, 32'h20);
    irq_in[5] = 0; idle(4);
    rd(12'h080, d); chk("R3 level high released", d, 0);
    wr(12'h3E4, 32'h100); idle(4);
    rd(12'h084, d); chk("R3 active-low pending", d, 32'h100);
    irq_in[40] = 1; idle(4);
    rd(12'h084, d); chk("R3 active-low idle", d, 0);
    irq_in[40] = 0; wr(12'h3E4, 32'h0); idle(4);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(12'h064, 32'h6);
    wr(12'h3E4, 32'h4);
    idle(3);
    wr(12'h084, 32'hFFFFFFFF);
    rd(12'h084, d); chk("R5 clear start", d, 0);
    irq_in[33] = 1; idle(4); irq_in[33] = 0; idle(4);
    rd(12'h084, d); chk("R4 rising latched", d, 32'h2);
    wr(12'h084, 32'hFFFFFFFD);
    rd(12'h084, d); chk("R5 zero bits ignored", d, 32'h2);
    wr(12'h084, 32'h2);
    rd(12'h084, d); chk("R5 one clears", d, 0);
    irq_in[34] = 1; idle(4);
    rd(12'h084, d); chk("R4 rise ignored on falling source", d, 0);
    irq_in[34] = 0; idle(4);
    rd(12'h084, d); chk("R4 falling latched", d, 32'h4);
    wr(12'h084, 32'h4);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    wr(12'h060, 32'h0010_0000);
    idle(2);
    irq_in[20] = 1;
    idle(2);
    wr(12'h080, 32'h0010_0000);
    rd(12'h080, d); chk("R11 edge beats clear", d, 32'h0010_0000);
    wr(12'h080, 32'h0010_0000);
    rd(12'h080, d); chk("R11 later clear drops", d, 0);
    irq_in[20] = 0;
  endtask

  task automatic t_msgs;
    logic [31:0] d;
    irq_in[3] = 1; irq_in[7] = 1;
    wr(12'h040, 32'h88); idle(4);
    chk("R6 masked sends nothing", 32'(msg_valid), 0);
    wr(12'h020, ~32'h88); idle(2);
    chk("R7 lowest first", 32'(msg_vector), 32'h43);
    idle(3);
    chk("R8 held valid", 32'(msg_valid), 1);
    take("R8 held content", 3);
    @(negedge clk);
    take("R7 next source", 7);
    idle(3);
    chk("R9 busy sources silent", 32'(msg_valid), 0);
    wr(12'h080, 32'h8); idle(2);
    take("R9 level resend after clear", 3);
    wr(12'h0C0, 32'hFFFFFFFF); wr(12'h0E0, 32'hFFFFFFFF);
    rd(12'h0C0, d); chk("R10 spare stored", d, 32'hFFFFFFFF);
    wr(12'h080, 32'h80); idle(2);
    take("R10 spare no effect", 7);
    irq_in[40] = 1;
    wr(12'h024, ~32'h100); idle(5);
    chk("R6 disabled sends nothing", 32'(msg_valid), 0);
    wr(12'h044, 32'h100); idle(2);
    take("R6 enabled source 40", 40);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset;
    t_regs;
    t_level;
    t_edge;
    t_same_cycle;
    t_msgs;
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule